// File: doc/BRIEF.md
# Multichannel DAC Setup and Volume Sequencer

This block produces the ordered stream of register writes that configures a six-channel audio DAC and keeps its volume and clock ratio up to date. Each write is an address and data pair: 7 bits of address and 9 bits of data. Writes are handed one at a time over a valid/ready interface to a separate three-wire serial transmitter. The block never drives the serial lines itself.

After reset the block runs its configuration sequence. It first issues a full device reset. It then stays silent for a programmable number of microseconds, measured with a divided clock. After that it mutes the three stereo pairs and loads the serial format, clock ratio and channel assignment registers.

Once that sequence has finished, the block accepts one runtime command at a time. A volume command targets a stereo pair and expands into two writes: the left value goes to the pair's even register, and the right value goes to the pair's odd register with bit 8 set. The device applies a pair's new levels together when that odd-register write carries bit 8. A rate command selects the master clock ratio from the sample rate.

Top module: `dac_setup_seq`

## Requirements
- R1: After reset, wr_valid_o is high and the first write is address 0x1F with data 0x000. cmd_ready_o is low.
- R2: After the reset write is accepted, wr_valid_o stays low for exactly WAIT_US*CLK_PER_US clock cycles.
- R3: The sequence then writes, in this order: 0x00=0x000, 0x01=0x100, 0x04=0x000, 0x05=0x100, 0x06=0x000, 0x07=0x100, 0x03=0x022, 0x0A=0x080, 0x12=0x000, 0x15=0x000, 0x09=0x000, 0x02=0x124, 0x02=0x120.
- R4: cmd_ready_o is high only after the last configuration write has been accepted and while no command writes remain. wr_valid_o is never high while cmd_ready_o is high.
- R5: A volume command (cmd_is_rate_i=0) to pair 0, 1 or 2 writes {0, left} to register 0x00, 0x04 or 0x06 respectively. It then writes {1, right} to the next odd register (0x01, 0x05 or 0x07). Volume 0 is mute and 0xFF is 0 dB.
- R6: A volume command to pair index 3 is accepted but produces no write, and cmd_ready_o stays high.
- R7: A rate command (cmd_is_rate_i=1) writes register 0x0A. The data is 0x000 when cmd_rate_i is above FAST_HZ (96000 by default) and 0x080 otherwise, including a rate equal to FAST_HZ.
- R8: A write offered on wr_valid_o holds its address and data until wr_ready_i accepts it. Writes are never dropped, repeated or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Runtime command offered |
| cmd_ready_o | output | 1 | Sequencer idle and able to take a command |
| cmd_is_rate_i | input | 1 | 1: rate command, 0: volume command |
| cmd_pair_i | input | 2 | Stereo pair index for volume commands |
| cmd_left_i | input | 8 | Left volume |
| cmd_right_i | input | 8 | Right volume |
| cmd_rate_i | input | RATE_W | Sample rate in Hz for rate commands |
| wr_valid_o | output | 1 | Register write offered to transmitter |
| wr_ready_i | input | 1 | Transmitter accepts the write |
| wr_addr_o | output | 7 | Register address |
| wr_data_o | output | 9 | Register data |

## Verification
The bench builds the block with CLK_PER_US=4 and WAIT_US=10. With these values the post-reset silence is 40 cycles, so the bench can count the whole window cycle by cycle instead of waiting thousands of cycles. RATE_W and FAST_HZ keep their defaults, so the bench can drive rates on both sides of 96000 and exactly at 96000. The bench also throttles the transmitter's ready signal, which exercises the hold behaviour mid-command and mid-script.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;
  localparam int ADDR_W     = 7;
  localparam int DATA_W     = 9;
  localparam int VOL_W      = DATA_W - 1;
  localparam int PAIR_W     = 2;
  localparam int NUM_PAIRS  = 3;
  localparam int SCRIPT_LEN = 13;
  localparam int SIDX_W     = $clog2(SCRIPT_LEN);

  localparam logic [ADDR_W-1:0] REG_FULL_RST = 7'h1F;
  localparam logic [ADDR_W-1:0] REG_CLK_RAT  = 7'h0A;
  localparam logic [DATA_W-1:0] CLK_RAT_256  = 9'h080;
  localparam logic [DATA_W-1:0] CLK_RAT_128  = 9'h000;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } dac_wr_t;

  typedef enum logic [2:0] {
    ST_RESET, ST_HOLD, ST_SCRIPT, ST_IDLE, ST_CMD
  } seq_state_e;

  function automatic logic [ADDR_W-1:0] pair_reg(input logic [PAIR_W-1:0] pair,
                                                 input logic odd);
    logic [ADDR_W-1:0] base;
    case (pair)
      2'd0:    base = 7'h00;
      2'd1:    base = 7'h04;
      default: base = 7'h06;
    endcase
    return base | {{(ADDR_W-1){1'b0}}, odd};
  endfunction

  // steps 0..5 mute the pairs; 6.. load format, clock, phase, assign
  function automatic dac_wr_t script_step(input logic [SIDX_W-1:0] idx);
    dac_wr_t w;
    if (idx < SIDX_W'(2*NUM_PAIRS)) begin
      w.addr = pair_reg(idx[2:1], idx[0]);
      w.data = idx[0] ? 9'h100 : 9'h000;
    end else begin
      case (idx)
        4'd6:    w = '{addr: 7'h03, data: 9'h022};
        4'd7:    w = '{addr: REG_CLK_RAT, data: CLK_RAT_256};
        4'd8:    w = '{addr: 7'h12, data: 9'h000};
        4'd9:    w = '{addr: 7'h15, data: 9'h000};
        4'd10:   w = '{addr: 7'h09, data: 9'h000};
        4'd11:   w = '{addr: 7'h02, data: 9'h124};
        default: w = '{addr: 7'h02, data: 9'h120};
      endcase
    end
    return w;
  endfunction
endpackage

// File: rtl/dac_us_timer.sv
module dac_us_timer #(
  parameter int CLK_PER_US = 200,
  parameter int WAIT_US    = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic done_o
);
  localparam int PW   = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam int UW   = (WAIT_US > 1) ? $clog2(WAIT_US) : 1;
  localparam int SPAN = CLK_PER_US * WAIT_US;
  localparam int SW   = $clog2(SPAN + 1);

  logic [PW-1:0] pre_q;
  logic [UW-1:0] us_q;
  logic          tick;

  assign tick   = (pre_q == PW'(CLK_PER_US - 1));
  assign done_o = run_i && tick && (us_q == UW'(WAIT_US - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (clr_i) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (run_i) begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick) us_q <= us_q + 1'b1;
    end
  end

  // independent cycle count since clear
  logic [SW-1:0] span_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   span_q <= '0;
    else if (clr_i)                                span_q <= '0;
    else if (run_i && span_q != SW'(SPAN))         span_q <= span_q + 1'b1;
  end

  a_r2_wait_span: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> span_q == SW'(SPAN - 1));
endmodule

// File: rtl/dac_cmd_unit.sv
module dac_cmd_unit
  import dac_seq_pkg::*;
#(
  parameter int RATE_W  = 18,
  parameter int FAST_HZ = 96000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 accept_i,
  input  logic                 is_rate_i,
  input  logic [PAIR_W-1:0]    pair_i,
  input  logic [VOL_W-1:0]     left_i,
  input  logic [VOL_W-1:0]     right_i,
  input  logic [RATE_W-1:0]    rate_i,
  input  logic                 adv_i,
  output logic                 takes_o,
  output dac_wr_t              wr_o,
  output logic                 last_o
);
  logic              busy_q, rate_q, fast_q, step_q;
  logic [PAIR_W-1:0] pair_q;
  logic [VOL_W-1:0]  left_q, right_q;

  assign takes_o = is_rate_i || (pair_i < PAIR_W'(NUM_PAIRS));
  assign last_o  = rate_q || step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      rate_q  <= 1'b0;
      fast_q  <= 1'b0;
      step_q  <= 1'b0;
      pair_q  <= '0;
      left_q  <= '0;
      right_q <= '0;
    end else if (accept_i) begin
      busy_q  <= takes_o;
      rate_q  <= is_rate_i;
      fast_q  <= rate_i > RATE_W'(FAST_HZ);
      step_q  <= 1'b0;
      pair_q  <= pair_i;
      left_q  <= left_i;
      right_q <= right_i;
    end else if (adv_i && busy_q) begin
      if (last_o) busy_q <= 1'b0;
      else        step_q <= 1'b1;
    end
  end

  always_comb begin
    if (rate_q) begin
      wr_o.addr = REG_CLK_RAT;
      wr_o.data = fast_q ? CLK_RAT_128 : CLK_RAT_256;
    end else begin
      wr_o.addr = pair_reg(pair_q, step_q);
      wr_o.data = step_q ? {1'b1, right_q} : {1'b0, left_q};
    end
  end

  a_r6_bad_pair_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && !is_rate_i && pair_i >= PAIR_W'(NUM_PAIRS)) |=> !busy_q);
  a_r5_left_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && !is_rate_i) |=> !step_q);
endmodule

// File: rtl/dac_setup_seq.sv
module dac_setup_seq
  import dac_seq_pkg::*;
#(
  parameter int CLK_PER_US = 200,
  parameter int WAIT_US    = 10,
  parameter int RATE_W     = 18,
  parameter int FAST_HZ    = 96000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic              cmd_is_rate_i,
  input  logic [1:0]        cmd_pair_i,
  input  logic [7:0]        cmd_left_i,
  input  logic [7:0]        cmd_right_i,
  input  logic [RATE_W-1:0] cmd_rate_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [6:0]        wr_addr_o,
  output logic [8:0]        wr_data_o
);
  seq_state_e        state_q;
  logic [SIDX_W-1:0] sidx_q;
  logic              wr_fire, cmd_fire, hold_done, cmd_takes, cmd_last;
  dac_wr_t           cmd_wr, cur_wr;

  assign wr_fire     = wr_valid_o && wr_ready_i;
  assign cmd_ready_o = (state_q == ST_IDLE);
  assign cmd_fire    = cmd_valid_i && cmd_ready_o;

  dac_us_timer #(.CLK_PER_US(CLK_PER_US), .WAIT_US(WAIT_US)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q == ST_RESET && wr_fire),
    .run_i  (state_q == ST_HOLD),
    .done_o (hold_done)
  );

  dac_cmd_unit #(.RATE_W(RATE_W), .FAST_HZ(FAST_HZ)) u_cmd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (cmd_fire),
    .is_rate_i (cmd_is_rate_i),
    .pair_i    (cmd_pair_i),
    .left_i    (cmd_left_i),
    .right_i   (cmd_right_i),
    .rate_i    (cmd_rate_i),
    .adv_i     (state_q == ST_CMD && wr_fire),
    .takes_o   (cmd_takes),
    .wr_o      (cmd_wr),
    .last_o    (cmd_last)
  );

  always_comb begin
    wr_valid_o = 1'b0;
    cur_wr     = cmd_wr;
    case (state_q)
      ST_RESET:  begin wr_valid_o = 1'b1; cur_wr = '{addr: REG_FULL_RST, data: '0}; end
      ST_SCRIPT: begin wr_valid_o = 1'b1; cur_wr = script_step(sidx_q); end
      ST_CMD:    wr_valid_o = 1'b1;
      default:   ;
    endcase
  end

  assign wr_addr_o = cur_wr.addr;
  assign wr_data_o = cur_wr.data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RESET;
      sidx_q  <= '0;
    end else begin
      case (state_q)
        ST_RESET:  if (wr_fire) state_q <= ST_HOLD;
        ST_HOLD:   if (hold_done) begin
                     state_q <= ST_SCRIPT;
                     sidx_q  <= '0;
                   end
        ST_SCRIPT: if (wr_fire) begin
                     if (sidx_q == SIDX_W'(SCRIPT_LEN - 1)) state_q <= ST_IDLE;
                     else sidx_q <= sidx_q + 1'b1;
                   end
        ST_IDLE:   if (cmd_fire && cmd_takes) state_q <= ST_CMD;
        ST_CMD:    if (wr_fire && cmd_last) state_q <= ST_IDLE;
        default:   state_q <= ST_RESET;
      endcase
    end
  end

  a_r8_hold_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));
  a_r4_ready_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !wr_valid_o);
  a_r5_update_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && wr_addr_o inside {7'h01, 7'h05, 7'h07}) |-> wr_data_o[8]);
  a_r1_reset_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RESET) |-> (wr_valid_o && wr_addr_o == 7'h1F && !cmd_ready_o));
endmodule

// File: tb/dac_setup_seq_bench.sv
module dac_setup_seq_bench;
  localparam int N = 4;
  localparam int W = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid = 1'b0, cmd_is_rate = 1'b0;
  logic [1:0]  cmd_pair = '0;
  logic [7:0]  cmd_left = '0, cmd_right = '0;
  logic [17:0] cmd_rate = '0;
  logic        cmd_ready, wr_valid, wr_ready;
  logic [6:0]  wr_addr;
  logic [8:0]  wr_data;

  always #2.5 clk = ~clk;

  dac_setup_seq #(.CLK_PER_US(N), .WAIT_US(W)) u_dac_setup_seq (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_is_rate_i(cmd_is_rate),
    .cmd_pair_i(cmd_pair), .cmd_left_i(cmd_left), .cmd_right_i(cmd_right),
    .cmd_rate_i(cmd_rate), .wr_valid_o(wr_valid), .wr_ready_i(wr_ready),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  int          vectors = 0, fails = 0, rem = 0, wait_cnt = 0, rcnt = 0;
  bit          first = 1'b1, stall = 1'b0, finished = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] got;
  logic [6:0]  base;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(input logic [6:0] a, input logic [8:0] d, input string tag);
    exp_q.push_back({a, d});
    tag_q.push_back(tag);
    rem++;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    #1;
    rcnt++;
    wr_ready = stall ? (rcnt % 3 == 0) : 1'b1;
  end

  // reference model, evaluated between edges for the coming edge
  always @(negedge clk) begin
    if (rst_ni && !finished) begin
      chk(wr_valid === (rem > 0 && wait_cnt == 0), (wait_cnt > 0) ? "R2" : "R8",
          int'(wr_valid), int'(rem > 0 && wait_cnt == 0));
      chk(cmd_ready === (rem == 0), "R4", int'(cmd_ready), int'(rem == 0));
      if (wr_valid && wr_ready) begin
        got = {wr_addr, wr_data};
        if (exp_q.size() == 0) chk(1'b0, "R8", int'(got), 0);
        else begin
          chk(got == exp_q[0], tag_q[0], int'(got), int'(exp_q[0]));
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
          rem--;
        end
      end
      if (wait_cnt > 0) wait_cnt--;
      if (wr_valid && wr_ready && first) begin
        wait_cnt = N * W;
        first = 1'b0;
      end
      if (cmd_valid && cmd_ready) begin
        if (cmd_is_rate) push(7'h0A, (cmd_rate > 18'd96000) ? 9'h000 : 9'h080, "R7");
        else if (cmd_pair < 2'd3) begin
          base = (cmd_pair == 2'd0) ? 7'h00 : (cmd_pair == 2'd1) ? 7'h04 : 7'h06;
          push(base, {1'b0, cmd_left}, "R5");
          push(base | 7'h01, {1'b1, cmd_right}, "R5");
        end
      end
    end
  end

  task automatic send(input bit is_rate, input logic [1:0] pair, input logic [7:0] l,
                      input logic [7:0] r, input logic [17:0] rate);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_is_rate = is_rate; cmd_pair = pair;
    cmd_left = l; cmd_right = r; cmd_rate = rate;
    do @(negedge clk); while (!cmd_ready);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  initial begin
    push(7'h1F, 9'h000, "R1");
    push(7'h00, 9'h000, "R3"); push(7'h01, 9'h100, "R3");
    push(7'h04, 9'h000, "R3"); push(7'h05, 9'h100, "R3");
    push(7'h06, 9'h000, "R3"); push(7'h07, 9'h100, "R3");
    push(7'h03, 9'h022, "R3"); push(7'h0A, 9'h080, "R3");
    push(7'h12, 9'h000, "R3"); push(7'h15, 9'h000, "R3");
    push(7'h09, 9'h000, "R3"); push(7'h02, 9'h124, "R3");
    push(7'h02, 9'h120, "R3");
    #12 rst_ni = 1'b1;
    send(1'b0, 2'd1, 8'h12, 8'h34, '0);      // held during the script: R4
    stall = 1'b1;
    send(1'b0, 2'd0, 8'hFF, 8'h00, '0);
    send(1'b1, 2'd0, 8'h00, 8'h00, 18'd96000);
    send(1'b1, 2'd0, 8'h00, 8'h00, 18'd96001);
    send(1'b0, 2'd3, 8'h77, 8'h88, '0);
    repeat (4) begin
      @(negedge clk);
      chk(!wr_valid && cmd_ready, "R6", int'({wr_valid, cmd_ready}), 1);
    end
    send(1'b0, 2'd2, 8'h5A, 8'hA5, '0);
    stall = 1'b0;
    send(1'b1, 2'd0, 8'h00, 8'h00, 18'd192000);
    send(1'b1, 2'd0, 8'h00, 8'h00, 18'd48000);
    send(1'b0, 2'd2, 8'h00, 8'hFF, '0);
    while (rem != 0) @(posedge clk);
    repeat (5) @(posedge clk);
    chk(exp_q.size() == 0, "R8", exp_q.size(), 0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    finish_run();
  end
endmodule